// File: doc/BRIEF.md
# Addressable Scan State Array

This block holds a row of state flip-flops that feed and are fed by surrounding combinational logic. Each flip-flop can also be reached on its own, like a memory cell, through an address. With the test control low, every cell loads its functional input on each clock edge. With the test control high, the cells keep their values. Test equipment then selects one cell by address, writes it from the serial input and reads it onto the serial output. The other cells do not move.

The address sits in a small serial register of `ADDR_W = clog2(N_CELLS)` bits. It is shifted in on the same serial input as the data, most significant bit first, while the shift enable is high. A decoder turns the stored address into a one-hot select. A single select cycle then performs one access:

- the addressed cell's old value is captured into the registered serial output;
- the serial input bit is written into that cell;
- the acknowledge output is pulsed.

Because only one bit changes per access, a tester can build single-input-change delay stimuli without shifting a whole chain. An address at or above `N_CELLS` gives an access that does nothing.

Top module: `ras_state_array`

## Requirements
- R1: While `rst_n` is low, `func_q`, `scan_out` and `ack` are 0 and the address register is 0.
- R2: When `test_ctl` is 0, every bit of `func_q` equals the `func_d` bit sampled at the previous rising edge.
- R3: When `test_ctl` is 1 and `addr_shift` is 1, the address register shifts left and loads `scan_in` into its bit 0, so that after `ADDR_W` such cycles the first bit sent is the address MSB. `addr_shift` has priority over `cell_sel`, and during the shift all cells hold.
- R4: An access is an edge with `test_ctl`=1, `cell_sel`=1, `addr_shift`=0 and an address below `N_CELLS`. An access loads `scan_in` into cell number `address`, where bit i of `func_q` is cell i, and leaves every other cell unchanged.
- R5: After an access, `scan_out` equals the value the addressed cell held just before that edge (read before write). In every other cycle `scan_out` is 0.
- R6: `ack` is 1 for exactly the one cycle after each access and 0 otherwise.
- R7: When `test_ctl` is 1 and no access or write occurs (`cell_sel`=0, or `addr_shift`=1), all cells hold their values.
- R8: With `test_ctl`=1, `cell_sel`=1, `addr_shift`=0 and an address of `N_CELLS` or more, no cell changes and `scan_out` and `ack` stay 0 in the next cycle.
- R9: When `test_ctl` is 0, `cell_sel` and `addr_shift` have no effect: cells capture `func_d`, `scan_out` and `ack` stay 0, and the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| func_d | input | N_CELLS | Functional next-state inputs from the logic |
| func_q | output | N_CELLS | Flip-flop outputs to the logic; bit i is cell i |
| test_ctl | input | 1 | 1 selects test access, 0 selects functional capture |
| cell_sel | input | 1 | Requests an access to the addressed cell |
| addr_shift | input | 1 | Shifts `scan_in` into the address register |
| scan_in | input | 1 | Serial address bit or write data |
| scan_out | output | 1 | Registered read data of the last access |
| ack | output | 1 | One-cycle pulse after a completed access |

## Verification
All flip-flop outputs are visible on `func_q` in every cycle. A corrupted cell or a write to the wrong cell therefore shows on the ports one cycle after the edge that caused it. A wrong address register stays hidden until the next select cycle. That access then flips the wrong bit of `func_q`, returns the wrong old value on `scan_out` and may drop `ack`, all in the cycle after the access. The bench models the cells and the address independently and compares all three outputs after every edge. Long random runs keep every address mistake short-lived.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_CAPTURE   = 2'd0,
        OP_HOLD      = 2'd1,
        OP_LOAD_ADDR = 2'd2,
        OP_ACCESS    = 2'd3
    } ras_op_e;

    typedef struct packed {
        logic scan_out;
        logic ack;
    } rd_state_t;

    // Priority: functional capture, then address shift, then cell access.
    function automatic ras_op_e ras_pick_op(logic tc, logic sel, logic shift);
        if (!tc)
            return OP_CAPTURE;
        else if (shift)
            return OP_LOAD_ADDR;
        else if (sel)
            return OP_ACCESS;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg
    import ras_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ras_op_e           op,
    input  logic              scan_in,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (op == OP_LOAD_ADDR)
            addr_d = ADDR_W'({addr_q, scan_in});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

endmodule

// File: rtl/ras_addr_decode.sv
module ras_addr_decode #(
    parameter int N_CELLS = 12,
    parameter int ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_CELLS-1:0] hit,
    output logic               in_range
);

    assign in_range = (int'(addr) < N_CELLS);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_dec
        assign hit[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/ras_cell.sv
module ras_cell
    import ras_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ras_op_e op,
    input  logic    hit,
    input  logic    func_d,
    input  logic    scan_in,
    output logic    q_q
);

    logic q_d;

    always_comb begin
        q_d = q_q;
        unique case (op)
            OP_CAPTURE: q_d = func_d;
            OP_ACCESS:  if (hit) q_d = scan_in;
            default:    q_d = q_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_q <= 1'b0;
        else
            q_q <= q_d;
    end

endmodule

// File: rtl/ras_readout.sv
module ras_readout
    import ras_pkg::*;
#(
    parameter int N_CELLS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ras_op_e            op,
    input  logic [N_CELLS-1:0] hit,
    input  logic               in_range,
    input  logic [N_CELLS-1:0] cell_q,
    output logic               scan_out,
    output logic               ack
);

    rd_state_t rd_d, rd_q;
    logic      picked;
    logic      access_ok;

    assign picked    = |(hit & cell_q);
    assign access_ok = (op == OP_ACCESS) && in_range;

    always_comb begin
        rd_d          = '0;
        rd_d.ack      = access_ok;
        rd_d.scan_out = access_ok & picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign scan_out = rd_q.scan_out;
    assign ack      = rd_q.ack;

endmodule

// File: rtl/ras_state_array.sv
module ras_state_array
    import ras_pkg::*;
#(
    parameter  int N_CELLS = 12,
    localparam int ADDR_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] func_d,
    output logic [N_CELLS-1:0] func_q,
    input  logic               test_ctl,
    input  logic               cell_sel,
    input  logic               addr_shift,
    input  logic               scan_in,
    output logic               scan_out,
    output logic               ack
);

    ras_op_e            op;
    logic [ADDR_W-1:0]  addr_q;
    logic [N_CELLS-1:0] hit;
    logic               in_range;

    assign op = ras_pick_op(test_ctl, cell_sel, addr_shift);

    ras_addr_reg #(.ADDR_W(ADDR_W)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .scan_in (scan_in),
        .addr_q  (addr_q)
    );

    ras_addr_decode #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) dec_i (
        .addr     (addr_q),
        .hit      (hit),
        .in_range (in_range)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        ras_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .hit     (hit[i]),
            .func_d  (func_d[i]),
            .scan_in (scan_in),
            .q_q     (func_q[i])
        );
    end

    ras_readout #(.N_CELLS(N_CELLS)) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .hit      (hit),
        .in_range (in_range),
        .cell_q   (func_q),
        .scan_out (scan_out),
        .ack      (ack)
    );

endmodule

// File: rtl/ras_state_array_chk.sv
module ras_state_array_chk #(
    parameter int N_CELLS = 12,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CELLS-1:0] func_d,
    input logic [N_CELLS-1:0] func_q,
    input logic               test_ctl,
    input logic               cell_sel,
    input logic               addr_shift,
    input logic               scan_in,
    input logic               scan_out,
    input logic               ack,
    input logic [ADDR_W-1:0]  addr
);

    logic valid_acc;
    logic bad_acc;

    assign valid_acc = test_ctl && cell_sel && !addr_shift && (int'(addr) < N_CELLS);
    assign bad_acc   = test_ctl && cell_sel && !addr_shift && (int'(addr) >= N_CELLS);

    // R1: reset values
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (func_q == '0 && !scan_out && !ack && addr == '0);
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_ctl |=> func_q == $past(func_d));

    p_addr_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_ctl && addr_shift) |=> addr == ADDR_W'({$past(addr), $past(scan_in)}));

    p_single_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_acc |=> $countones(func_q ^ $past(func_q)) <= 1);

    p_read_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_acc |=> scan_out == $past(func_q[addr]));

    p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> !scan_out);

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_acc |=> ack);

    p_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_acc |=> !ack);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_ctl && (addr_shift || !cell_sel)) |=> $stable(func_q));

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> ($stable(func_q) && !ack && !scan_out));

    p_func_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_ctl |=> ($stable(addr) && !ack));

endmodule

bind ras_state_array ras_state_array_chk #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .func_d     (func_d),
    .func_q     (func_q),
    .test_ctl   (test_ctl),
    .cell_sel   (cell_sel),
    .addr_shift (addr_shift),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .ack        (ack),
    .addr       (addr_q)
);

// File: tb/ras_state_array_tb.sv
`timescale 1ns/1ps
module ras_state_array_tb_top;

    localparam int N  = 12;
    localparam int AW = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] func_q;
    logic         test_ctl = 1'b0;
    logic         cell_sel = 1'b0;
    logic         addr_shift = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic         ack;

    int n_chk = 0;
    int n_bad = 0;

    logic [N-1:0] m_q   = '0;
    int           m_addr = 0;

    always #2.5 clk = ~clk;

    ras_state_array #(.N_CELLS(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .func_d     (func_d),
        .func_q     (func_q),
        .test_ctl   (test_ctl),
        .cell_sel   (cell_sel),
        .addr_shift (addr_shift),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .ack        (ack)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock step: drive, compute the expected next state, sample after the edge.
    task automatic step(logic tc, logic sel, logic sh, logic sin, logic [N-1:0] d);
        logic [N-1:0] nq;
        logic         nso, nack;
        string        tq, to, ta;
        @(negedge clk);
        test_ctl = tc; cell_sel = sel; addr_shift = sh; scan_in = sin; func_d = d;
        nq = m_q; nso = 1'b0; nack = 1'b0;
        if (!tc) begin
            nq = d;
            tq = sel ? "R9 q" : "R2 q"; to = "R9 so"; ta = "R9 ack";
        end else if (sh) begin
            m_addr = ((m_addr << 1) | int'(sin)) % (1 << AW);
            tq = "R3/R7 q"; to = "R3 so"; ta = "R3 ack";
        end else if (sel) begin
            if (m_addr < N) begin
                nso = m_q[m_addr];
                nack = 1'b1;
                nq[m_addr] = sin;
                tq = "R4 q"; to = "R5 so"; ta = "R6 ack";
            end else begin
                tq = "R8 q"; to = "R8 so"; ta = "R8 ack";
            end
        end else begin
            tq = "R7 q"; to = "R7 so"; ta = "R6 ack";
        end
        @(posedge clk);
        #1;
        m_q = nq;
        chk(tq, 32'(func_q), 32'(nq));
        chk(to, 32'(scan_out), 32'(nso));
        chk(ta, 32'(ack), 32'(nack));
    endtask

    task automatic load_addr(int a);
        for (int k = AW - 1; k >= 0; k--)
            step(1'b1, 1'b0, 1'b1, a[k], N'($urandom));
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20260611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 q", 32'(func_q), 0);
        chk("R1 so", 32'(scan_out), 0);
        chk("R1 ack", 32'(ack), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R9: functional capture, select ignored
        step(1'b0, 1'b0, 1'b0, 1'b0, 12'hA5A);
        step(1'b0, 1'b1, 1'b0, 1'b1, 12'h5A5);
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'hF0F);
        // R1/R9: address still 0 -> access cell 0 (holds 1) reading old value
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);

        // R3/R4/R5: address 5, write 1 then read back writing 0
        load_addr(5);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);
        // boundaries: last valid cell
        load_addr(N - 1);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0);
        // R7: hold
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF);
        // R8: out of range addresses
        load_addr(N);
        step(1'b1, 1'b1, 1'b0, 1'b1, '0);
        load_addr((1 << AW) - 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, '0);

        // random mix
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 2)
                step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), N'($urandom));
            else if (r < 4)
                step(1'b1, 1'($urandom), 1'b1, 1'($urandom), N'($urandom));
            else if (r < 9)
                step(1'b1, 1'b1, 1'b0, 1'($urandom), N'($urandom));
            else
                step(1'b1, 1'b0, 1'b0, 1'($urandom), N'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule